// File: doc/BRIEF.md
# Push-Button Wake and Reset Controller

This block watches one active-low push-button. It filters contact bounce and measures how long the button stays down in millisecond ticks. Four programmable points are checked in a fixed order during a hold: a first wake point, a second wake point, a warning point and a long-press point. Each of the first three points sets an event flag. The host clears a flag with a read strobe. An active-low interrupt pulse of fixed length goes out only when a flag goes from clear to set.

The block also takes part in the low-power (ship) state of the product. While the product is in ship mode, a press held to the first wake point requests an exit from ship mode. A shorter press leaves the product in ship mode. A valid supply input requests the exit at once.

At the long-press point the block carries out the configured action: a power cycle, entry into ship mode, or nothing. A power cycle drops the rail-enable output for a programmable restart time and then always raises it again. Software can also start a power cycle.

Top module: `pb_wake_reset_ctrl`

## Requirements
- R1: A change on `btn_n` that lasts fewer than `DB_CYC` clocks is ignored: it sets no flag and sends no interrupt.
- R2: Holding the button for `cfg_wake1_ms` ticks sets `flags[0]` and drives `int_n` low for exactly `INT_CYC` clocks.
- R3: Continuing to hold for `cfg_wake2_ms` ticks sets `flags[1]` and sends a second interrupt pulse.
- R4: An interrupt is sent only when a flag goes from clear to set. A set flag stays set until its bit in `flag_rd` is pulsed for one clock, and that pulse clears it.
- R5: The warning flag `flags[2]` is set, with an interrupt, when the hold reaches `cfg_hwrst_ms - cfg_warn_ms` ticks.
- R6: With `cfg_action` = 2'b00 (power cycle), reaching `cfg_hwrst_ms` drives `rail_en` low. It returns high about `cfg_restart_ms` ticks later, whatever the button does.
- R7: With `cfg_action` = 2'b01 (ship), `ship_enter_req` pulses only after both the long-press point has been reached and the button has been released.
- R8: With `cfg_action` = 2'b10 or 2'b11 (no action), the long-press point changes neither `rail_en` nor `ship_enter_req`.
- R9: During a press the action may be changed to ship or no action. A change to power cycle from another action is refused. When `cfg_cycle_needs_vin` is 1, the power cycle happens only if `vin_valid` stayed high for the whole press.
- R10: A press that begins while `in_ship` is 1 sets no flag. It raises `ship_exit_req` once held to the first wake point. If released earlier, it raises nothing.
- R11: While `in_ship` is 1, `vin_valid` high raises `ship_exit_req` within two clocks, with or without a press.
- R12: A press that is still held when the ship-mode exit is requested produces no flag, interrupt or long-press action until the button is released and pressed again.
- R13: A new value written to a threshold while that threshold is still pending in a press takes effect only from the next press.
- R14: A one-clock pulse on `sw_cycle_req` starts the same power cycle as R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ms_tick | input | 1 | One-clock pulse every millisecond |
| btn_n | input | 1 | Raw button, low when pressed |
| cfg_wake1_ms | input | TW | First wake point in ticks |
| cfg_wake2_ms | input | TW | Second wake point in ticks |
| cfg_warn_ms | input | TW | Warning margin before the long-press point |
| cfg_hwrst_ms | input | TW | Long-press point in ticks |
| cfg_action | input | 2 | 00 power cycle, 01 ship, 1x nothing |
| cfg_cycle_needs_vin | input | 1 | Power cycle requires valid input for the whole press |
| cfg_restart_ms | input | TW | Rail-off time of a power cycle |
| sw_cycle_req | input | 1 | Software power-cycle request pulse |
| vin_valid | input | 1 | Supply input valid |
| in_ship | input | 1 | Product is in ship mode |
| flag_rd | input | 3 | Read strobes that clear flags |
| flags | output | 3 | Flags: bit0 wake1, bit1 wake2, bit2 warning |
| int_n | output | 1 | Active-low interrupt pulse |
| ship_exit_req | output | 1 | Request to leave ship mode |
| ship_enter_req | output | 1 | One-clock request to enter ship mode |
| rail_en | output | 1 | System rail enable, low during a power cycle |

## Verification
The hardest situation to reach is a press that outlives its own ship-mode exit. The button must go down while ship status is high. The exit must then be requested, either by the wake point or by a valid input arriving mid-press. The bench, acting as the power logic, then drops ship status while the button is still held, and keeps holding it past every threshold. It checks that the locked press stays silent and that the next fresh press behaves normally. Refused upgrades and the input-validity gate are reached by changing the action or `vin_valid` part way through a held press.

// File: rtl/pb_pkg.sv
package pb_pkg;
  localparam logic [1:0] ACT_CYCLE = 2'b00;
  localparam logic [1:0] ACT_SHIP  = 2'b01;
  localparam int NUM_THR  = 4;
  localparam int NUM_FLAG = 3;
  localparam int THR_WAKE1 = 0;
  localparam int THR_HWRST = 3;
endpackage

// File: rtl/pb_debounce.sv
module pb_debounce #(
  parameter int DB_CYC = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic btn_n,
  output logic pressed
);
  localparam int CW = $clog2(DB_CYC + 1);
  logic [1:0]    sync_q;
  logic          raw_p;
  logic [CW-1:0] cnt;

  assign raw_p = sync_q[1];

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q  <= 2'b00;
      cnt     <= '0;
      pressed <= 1'b0;
    end else begin
      sync_q <= {sync_q[0], ~btn_n};
      if (raw_p == pressed) begin
        cnt <= '0;
      end else if (cnt == CW'(DB_CYC - 1)) begin
        cnt     <= '0;
        pressed <= raw_p;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  AST_DB_STABLE: assert property (@(posedge clk) disable iff (rst)
    $rose(pressed) |-> $past(raw_p)); // R1
endmodule

// File: rtl/pb_hold_timer.sv
module pb_hold_timer #(
  parameter int TW   = 16,
  parameter int NTHR = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     ms_tick,
  input  logic                     pressed,
  input  logic                     en,
  input  logic [NTHR-1:0][TW-1:0]  cfg_thr,
  output logic [NTHR-1:0]          ev
);
  logic [TW-1:0]           cnt;
  logic [NTHR-1:0][TW-1:0] shadow;
  logic [NTHR-1:0]         fired;

  always_ff @(posedge clk) begin
    if (rst || !pressed) cnt <= '0;
    else if (en && ms_tick && cnt != '1) cnt <= cnt + 1'b1;
  end

  for (genvar k = 0; k < NTHR; k++) begin : g_thr
    assign ev[k] = pressed && en && !fired[k] && (cnt >= shadow[k]);

    always_ff @(posedge clk) begin
      if (rst) begin
        shadow[k] <= '0;
        fired[k]  <= 1'b0;
      end else begin
        if (!pressed || fired[k]) shadow[k] <= cfg_thr[k];
        if (!pressed) fired[k] <= 1'b0;
        else if (ev[k]) fired[k] <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/pb_int_pulse.sv
module pb_int_pulse #(
  parameter int INT_CYC = 16000
) (
  input  logic clk,
  input  logic rst,
  input  logic trig,
  output logic int_n
);
  localparam int CW = $clog2(INT_CYC + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      int_n <= 1'b1;
    end else if (trig) begin
      cnt   <= CW'(INT_CYC);
      int_n <= 1'b0;
    end else if (cnt != '0) begin
      cnt   <= cnt - 1'b1;
      int_n <= (cnt == CW'(1));
    end
  end

  AST_INT_ENDS: assert property (@(posedge clk) disable iff (rst)
    (!int_n && cnt == CW'(1) && !trig) |=> int_n); // R2
endmodule

// File: rtl/pb_restart.sv
module pb_restart #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ms_tick,
  input  logic          start,
  input  logic [TW-1:0] cfg_restart_ms,
  output logic          rail_en
);
  logic [TW-1:0] cnt;
  logic [TW-1:0] target;

  always_ff @(posedge clk) begin
    if (rst) begin
      rail_en <= 1'b1;
      cnt     <= '0;
      target  <= '0;
    end else if (rail_en) begin
      if (start) begin
        rail_en <= 1'b0;
        cnt     <= '0;
        target  <= cfg_restart_ms;
      end
    end else if (ms_tick) begin
      if (cnt >= target) rail_en <= 1'b1;
      else cnt <= cnt + 1'b1;
    end
  end

  AST_CYCLE_CAUSE: assert property (@(posedge clk) disable iff (rst)
    $fell(rail_en) |-> $past(start)); // R6
endmodule

// File: rtl/pb_wake_reset_ctrl.sv
module pb_wake_reset_ctrl
  import pb_pkg::*;
#(
  parameter int TW      = 16,
  parameter int DB_CYC  = 8,
  parameter int INT_CYC = 16000
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                ms_tick,
  input  logic                btn_n,
  input  logic [TW-1:0]       cfg_wake1_ms,
  input  logic [TW-1:0]       cfg_wake2_ms,
  input  logic [TW-1:0]       cfg_warn_ms,
  input  logic [TW-1:0]       cfg_hwrst_ms,
  input  logic [1:0]          cfg_action,
  input  logic                cfg_cycle_needs_vin,
  input  logic [TW-1:0]       cfg_restart_ms,
  input  logic                sw_cycle_req,
  input  logic                vin_valid,
  input  logic                in_ship,
  input  logic [NUM_FLAG-1:0] flag_rd,
  output logic [NUM_FLAG-1:0] flags,
  output logic                int_n,
  output logic                ship_exit_req,
  output logic                ship_enter_req,
  output logic                rail_en
);
  logic                       pressed, pressed_d, press_rise;
  logic [NUM_THR-1:0][TW-1:0] cfg_thr;
  logic [NUM_THR-1:0]         ev;
  logic                       locked, ship_press, exit_lat, vin_ok, ship_pend;
  logic [1:0]                 act_lat;
  logic                       act_ev, cyc_start;
  logic [NUM_FLAG-1:0]        flag_set;
  logic                       int_trig;

  assign press_rise = pressed && !pressed_d;
  assign cfg_thr[0] = cfg_wake1_ms;
  assign cfg_thr[1] = cfg_wake2_ms;
  assign cfg_thr[2] = (cfg_hwrst_ms > cfg_warn_ms) ? cfg_hwrst_ms - cfg_warn_ms : '0;
  assign cfg_thr[3] = cfg_hwrst_ms;

  pb_debounce #(.DB_CYC(DB_CYC)) u_db (
    .clk(clk), .rst(rst), .btn_n(btn_n), .pressed(pressed));

  pb_hold_timer #(.TW(TW), .NTHR(NUM_THR)) u_tmr (
    .clk(clk), .rst(rst), .ms_tick(ms_tick), .pressed(pressed),
    .en(!locked), .cfg_thr(cfg_thr), .ev(ev));

  assign flag_set  = ev[NUM_FLAG-1:0] & {NUM_FLAG{!ship_press}};
  assign int_trig  = |(flag_set & ~flags);
  assign act_ev    = ev[THR_HWRST] && !ship_press;
  assign cyc_start = (act_ev && act_lat == ACT_CYCLE &&
                      (!cfg_cycle_needs_vin || (vin_ok && vin_valid))) || sw_cycle_req;

  pb_int_pulse #(.INT_CYC(INT_CYC)) u_int (
    .clk(clk), .rst(rst), .trig(int_trig), .int_n(int_n));

  pb_restart #(.TW(TW)) u_rst (
    .clk(clk), .rst(rst), .ms_tick(ms_tick), .start(cyc_start),
    .cfg_restart_ms(cfg_restart_ms), .rail_en(rail_en));

  always_ff @(posedge clk) begin
    if (rst) begin
      pressed_d      <= 1'b0;
      locked         <= 1'b0;
      ship_press     <= 1'b0;
      exit_lat       <= 1'b0;
      ship_exit_req  <= 1'b0;
      act_lat        <= 2'b10;
      vin_ok         <= 1'b0;
      ship_pend      <= 1'b0;
      ship_enter_req <= 1'b0;
      flags          <= '0;
    end else begin
      pressed_d <= pressed;
      if (!pressed) locked <= 1'b0;
      else if ((in_ship && vin_valid) || (ship_press && ev[THR_WAKE1])) locked <= 1'b1;

      if (press_rise) ship_press <= in_ship;
      else if (!pressed) ship_press <= 1'b0;

      if (!in_ship) exit_lat <= 1'b0;
      else if (ship_press && ev[THR_WAKE1]) exit_lat <= 1'b1;
      ship_exit_req <= in_ship && (vin_valid || exit_lat);

      if (press_rise) begin
        act_lat <= cfg_action;
        vin_ok  <= vin_valid;
      end else if (pressed) begin
        if (!(cfg_action == ACT_CYCLE && act_lat != ACT_CYCLE)) act_lat <= cfg_action;
        if (!vin_valid) vin_ok <= 1'b0;
      end

      ship_enter_req <= 1'b0;
      if (act_ev && act_lat == ACT_SHIP) ship_pend <= 1'b1;
      else if (ship_pend && !pressed) begin
        ship_pend      <= 1'b0;
        ship_enter_req <= 1'b1;
      end

      flags <= (flags & ~flag_rd) | flag_set;
    end
  end

  for (genvar k = 0; k < NUM_FLAG; k++) begin : g_flag_chk
    AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (rst)
      (flags[k] && !flag_rd[k]) |=> flags[k]); // R4
  end

  AST_SHIP_AFTER_RELEASE: assert property (@(posedge clk) disable iff (rst)
    ship_enter_req |-> !pressed); // R7

  AST_EXIT_IN_SHIP: assert property (@(posedge clk) disable iff (rst)
    ship_exit_req |-> $past(in_ship)); // R10
endmodule

// File: tb/pb_wake_reset_ctrl_tb.sv
module pb_wake_reset_ctrl_tb;
  localparam int TW = 16;
  localparam int INT_CYC = 16;
  localparam int TICK_DIV = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ms_tick = 1'b0;
  logic btn_n = 1'b1;
  logic [TW-1:0] w1 = 16'd3, w2 = 16'd6, warn = 16'd3, hw = 16'd12, rs = 16'd4;
  logic [1:0] act = 2'b10;
  logic needs_vin = 1'b0, sw_req = 1'b0, vin = 1'b0, ship = 1'b0;
  logic [2:0] rd = 3'b000;
  logic [2:0] flags;
  logic int_n, exit_req, enter_req, rail_en;

  int n_chk = 0, n_fail = 0, tick_cnt = 0;
  logic [2:0] exp_q[$];
  logic rail_low_seen = 1'b0, enter_seen = 1'b0;

  always #4 clk = ~clk;

  always @(posedge clk) begin
    tick_cnt <= (tick_cnt == TICK_DIV - 1) ? 0 : tick_cnt + 1;
    ms_tick  <= (tick_cnt == TICK_DIV - 1);
  end

  pb_wake_reset_ctrl #(.TW(TW), .DB_CYC(4), .INT_CYC(INT_CYC)) u_dut (
    .clk(clk), .rst(rst), .ms_tick(ms_tick), .btn_n(btn_n),
    .cfg_wake1_ms(w1), .cfg_wake2_ms(w2), .cfg_warn_ms(warn), .cfg_hwrst_ms(hw),
    .cfg_action(act), .cfg_cycle_needs_vin(needs_vin), .cfg_restart_ms(rs),
    .sw_cycle_req(sw_req), .vin_valid(vin), .in_ship(ship), .flag_rd(rd),
    .flags(flags), .int_n(int_n), .ship_exit_req(exit_req),
    .ship_enter_req(enter_req), .rail_en(rail_en));

  task automatic chk(input bit ok, input string req, input int act_v, input int exp_v);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act_v, exp_v);
    end
  endtask

  // monitor: interrupts are compared against the scoreboard queue
  logic prev_int = 1'b1;
  int low_len = 0;
  always @(negedge clk) begin
    if (!rst) begin
      if (!rail_en) rail_low_seen = 1'b1;
      if (enter_req) enter_seen = 1'b1;
      if (prev_int && !int_n) begin
        if (exp_q.size() == 0) chk(0, "R4 unexpected interrupt", int'(flags), -1);
        else begin
          logic [2:0] e;
          e = exp_q.pop_front();
          chk(flags == e, "R2/R3/R5 flags at interrupt", int'(flags), int'(e));
        end
        low_len = 1;
      end else if (!int_n) low_len++;
      else if (!prev_int) chk(low_len == INT_CYC, "R2 interrupt width", low_len, INT_CYC);
      prev_int = int_n;
    end
  end

  task automatic wait_ms(input int ms);
    repeat (ms * TICK_DIV) @(negedge clk);
  endtask

  task automatic expect_int(input logic [2:0] f);
    exp_q.push_back(f);
  endtask

  task automatic clear_flags();
    @(negedge clk) rd = 3'b111;
    @(negedge clk) rd = 3'b000;
  endtask

  task automatic hold(input int ms);
    btn_n = 1'b0;
    wait_ms(ms);
    btn_n = 1'b1;
    wait_ms(2);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(int_n && flags == 3'b000 && rail_en && !exit_req && !enter_req,
        "R2 reset state", int'(flags), 0);

    // R1: short glitch ignored
    btn_n = 1'b0; repeat (2) @(negedge clk); btn_n = 1'b1;
    wait_ms(6);
    chk(flags == 3'b000, "R1 glitch ignored", int'(flags), 0);

    // R2 R3 R5 R8: full hold with no action
    expect_int(3'b001); expect_int(3'b011); expect_int(3'b111);
    rail_low_seen = 0; enter_seen = 0;
    hold(14);
    chk(flags == 3'b111, "R5 all flags set", int'(flags), 7);
    chk(!rail_low_seen && !enter_seen, "R8 no action", int'(rail_low_seen), 0);

    // R4: flags already set, no new interrupts; read clears
    hold(14);
    chk(flags == 3'b111, "R4 flags held", int'(flags), 7);
    clear_flags();
    @(negedge clk);
    chk(flags == 3'b000, "R4 read clears", int'(flags), 0);

    // R6: power cycle action
    act = 2'b00;
    expect_int(3'b001); expect_int(3'b011); expect_int(3'b111);
    btn_n = 1'b0;
    wait_ms(14);
    chk(!rail_en, "R6 rail dropped", int'(rail_en), 0);
    btn_n = 1'b1;
    wait_ms(8);
    chk(rail_en, "R6 rail restored", int'(rail_en), 1);

    // R7: ship action only after release (flags stay set -> silent)
    act = 2'b01; enter_seen = 0;
    btn_n = 1'b0;
    wait_ms(14);
    chk(!enter_seen, "R7 no ship entry while held", int'(enter_seen), 0);
    btn_n = 1'b1;
    wait_ms(1);
    chk(enter_seen, "R7 ship entry after release", int'(enter_seen), 1);

    // R9: upgrade to cycle refused
    act = 2'b01; enter_seen = 0; rail_low_seen = 0;
    btn_n = 1'b0; wait_ms(2); act = 2'b00; wait_ms(12); btn_n = 1'b1; wait_ms(2);
    chk(!rail_low_seen && enter_seen, "R9 upgrade refused", int'(rail_low_seen), 0);
    // R9: downgrade accepted
    act = 2'b00; rail_low_seen = 0; enter_seen = 0;
    btn_n = 1'b0; wait_ms(2); act = 2'b10; wait_ms(12); btn_n = 1'b1; wait_ms(2);
    chk(!rail_low_seen && !enter_seen, "R9 downgrade taken", int'(rail_low_seen), 0);
    // R9: input gating
    act = 2'b00; needs_vin = 1'b1; vin = 1'b1; rail_low_seen = 0;
    btn_n = 1'b0; wait_ms(2); vin = 1'b0; wait_ms(1); vin = 1'b1; wait_ms(11);
    btn_n = 1'b1; wait_ms(2);
    chk(!rail_low_seen, "R9 vin gate blocks cycle", int'(rail_low_seen), 0);
    needs_vin = 1'b0; vin = 1'b0;
    clear_flags();

    // R10: ship-mode press, short release stays in ship
    ship = 1'b1;
    hold(2);
    chk(!exit_req && flags == 3'b000, "R10 short press no exit", int'(exit_req), 0);
    // R10 R12: held to wake1, exit then stays silent while held
    rail_low_seen = 0;
    btn_n = 1'b0;
    wait_ms(5);
    chk(exit_req && flags == 3'b000, "R10 exit at wake1", int'(exit_req), 1);
    ship = 1'b0;
    wait_ms(10);
    btn_n = 1'b1; wait_ms(2);
    chk(flags == 3'b000 && !rail_low_seen, "R12 held press locked", int'(flags), 0);
    expect_int(3'b001);
    hold(4);
    chk(flags == 3'b001, "R12 fresh press works", int'(flags), 1);
    clear_flags();

    // R11: valid input in ship exits at once
    ship = 1'b1;
    @(negedge clk) vin = 1'b1;
    repeat (2) @(negedge clk);
    chk(exit_req, "R11 vin exit", int'(exit_req), 1);
    ship = 1'b0; vin = 1'b0;
    @(negedge clk);
    ship = 1'b1;
    btn_n = 1'b0; wait_ms(1);
    vin = 1'b1; repeat (2) @(negedge clk);
    chk(exit_req, "R11 vin exit during press", int'(exit_req), 1);
    ship = 1'b0;
    wait_ms(14); btn_n = 1'b1; wait_ms(2);
    chk(flags == 3'b000 && rail_en, "R12 locked after vin exit", int'(flags), 0);
    vin = 1'b0;

    // R13: deferred threshold change
    act = 2'b10;
    expect_int(3'b001); expect_int(3'b011);
    btn_n = 1'b0; wait_ms(1); w2 = 16'd20; wait_ms(7);
    chk(flags == 3'b011, "R13 old wake2 used", int'(flags), 3);
    btn_n = 1'b1; wait_ms(2);
    clear_flags();
    expect_int(3'b001);
    btn_n = 1'b0; wait_ms(8);
    chk(flags == 3'b001, "R13 new wake2 next press", int'(flags), 1);
    btn_n = 1'b1; wait_ms(2);
    w2 = 16'd6;
    clear_flags();

    // R14: software power cycle
    @(negedge clk) sw_req = 1'b1;
    @(negedge clk) sw_req = 1'b0;
    wait_ms(2);
    chk(!rail_en, "R14 sw cycle drops rail", int'(rail_en), 0);
    wait_ms(6);
    chk(rail_en, "R14 sw cycle completes", int'(rail_en), 1);

    wait_ms(2);
    chk(exp_q.size() == 0, "R2 missing interrupts", exp_q.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule